// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block decides which of ten interrupt vectors the CPU enters next, and when. Each vector has a sticky pending flag, set by its request line and cleared either when the vector is taken or by an explicit clear. A per-vector select bit places the vector at the low level or at an elevated level. The elevated level is the highest level for the first two vectors and the high level for the other eight. Among eligible requests, a higher level beats a lower one. Within one level, the lowest vector address wins.

Nesting uses one in-service bit per level. A request is accepted only when its level is strictly above the highest level now in service. A request at the same or a lower level stays pending until the handlers above it return. On acceptance the controller raises a one-clock take strobe and presents the vector's entry address. A return-from-interrupt pulse retires the highest in-service level. A global enable gates all acceptance but leaves the pending flags as they are.

Top module: `irq3_vic`

## Requirements
- R1: After reset `take_o` is 0, `vec_addr_o` is 0, no vector is pending and no level is in service.
- R2: The vector with index i (0 to 9, i = 0 being the first) has address 0x03 + 8*i, placed on `vec_addr_o` in the cycle `take_o` is high.
- R3: `lvl_sel_i[i]` = 0 places vector i at the low level. `lvl_sel_i[i]` = 1 places vectors 0 and 1 at the highest level and vectors 2 to 9 at the high level.
- R4: When eligible requests of different levels are pending together, the one at the higher level is taken first.
- R5: When eligible requests of the same level are pending together, the lowest vector index is taken first.
- R6: A pending request is taken only if its level is strictly above the highest in-service level. A request at an equal or lower level remains pending.
- R7: A request that is high at clock edge k is taken at edge k+1 at the earliest. `take_o` is high for one clock for each accepted vector.
- R8: A high `reti_i` at an edge clears the highest in-service level at that edge. A request held by that level may be taken at the following edge.
- R9: While `gie_i` is 0 nothing is taken, and pending requests survive until `gie_i` returns to 1.
- R10: `clr_i[i]` drops the pending flag of vector i. When `irq_i[i]` and `clr_i[i]` are high at the same edge, the clear wins.
- R11: A take marks its level as in service, so the in-service set grows. A `reti_i` with nothing in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 10 | Request lines, one per vector, sampled each edge |
| clr_i | input | 10 | Pending clear, one per vector |
| lvl_sel_i | input | 10 | Level select per vector (0 low, 1 elevated) |
| gie_i | input | 1 | Global acceptance enable |
| reti_i | input | 1 | Return from interrupt, retires highest in-service level |
| take_o | output | 1 | One-clock strobe: vector accepted |
| vec_addr_o | output | 8 | Entry address of the last accepted vector |

## Verification
The bench builds a three-deep nest (low, then high, then highest) and unwinds it one return at a time. A controller that cleared the wrong in-service bit, or that compared levels with greater-or-equal, would release a held request one return too early. Simultaneous requests at low and elevated levels, and several at the same level, expose wrong level ordering or a tie broken toward the higher address. Further stimulus clears a request on the same edge it is raised and drops the global enable while requests are waiting. A design that let the set beat the clear, or that discarded pending flags while disabled, would take the vector in the first case or never take it in the second. A long random phase follows, compared against the reference model on every clock.

// File: rtl/irq3_pkg.sv
package irq3_pkg;
  localparam int unsigned NUM_LVL = 3;

  typedef enum logic [1:0] {
    LVL_LO  = 2'd0,
    LVL_HI  = 2'd1,
    LVL_TOP = 2'd2
  } lvl_e;

  // elevated select maps the first num_top vectors to the top level
  function automatic lvl_e vec_level(int unsigned idx, int unsigned num_top, logic sel);
    if (!sel) return LVL_LO;
    return (idx < num_top) ? LVL_TOP : LVL_HI;
  endfunction
endpackage

// File: rtl/irq3_pend_bank.sv
module irq3_pend_bank #(
  parameter int unsigned NUM_VEC = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  input  logic [NUM_VEC-1:0] take_i,
  output logic [NUM_VEC-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= ((pend_o & ~take_i) | set_i) & ~clr_i;
  end
endmodule

// File: rtl/irq3_arbiter.sv
module irq3_arbiter
  import irq3_pkg::*;
#(
  parameter int unsigned NUM_VEC = 10,
  parameter int unsigned NUM_TOP = 2,
  localparam int unsigned IDX_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] pend_i,
  input  logic [NUM_VEC-1:0] sel_i,
  input  logic               gie_i,
  input  logic [NUM_LVL-1:0] svc_i,
  output logic               grant_o,
  output logic [IDX_W-1:0]   grant_idx_o,
  output logic [NUM_VEC-1:0] grant_mask_o,
  output lvl_e               grant_lvl_o
);
  lvl_e               vec_lvl [NUM_VEC];
  logic [NUM_LVL-1:0] lvl_open;
  logic [NUM_LVL-1:0] hit;
  logic [NUM_VEC-1:0] req_l [NUM_LVL];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign vec_lvl[v] = vec_level(v, NUM_TOP, sel_i[v]);
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    // level l may preempt only if nothing at l or above is in service
    assign lvl_open[l] = ~|svc_i[NUM_LVL-1:l];
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_req
      assign req_l[l][v] = pend_i[v] & gie_i & lvl_open[l] & (vec_lvl[v] == lvl_e'(l));
    end
    assign hit[l] = |req_l[l];
  end

  always_comb begin
    grant_o     = |hit;
    grant_lvl_o = LVL_LO;
    for (int l = 0; l < NUM_LVL; l++)
      if (hit[l]) grant_lvl_o = lvl_e'(l);
    grant_idx_o = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--)
      if (req_l[grant_lvl_o][v]) grant_idx_o = IDX_W'(v);
    grant_mask_o = grant_o ? (NUM_VEC'(1) << grant_idx_o) : '0;
  end
endmodule

// File: rtl/irq3_svc_stack.sv
module irq3_svc_stack
  import irq3_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  lvl_e               push_lvl_i,
  input  logic               pop_i,
  output logic [NUM_LVL-1:0] svc_o
);
  logic [NUM_LVL-1:0] top_mask, push_mask;

  always_comb begin
    top_mask = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (svc_o[l]) top_mask = NUM_LVL'(1) << l;
    push_mask = push_i ? (NUM_LVL'(1) << push_lvl_i) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_o <= '0;
    else         svc_o <= (svc_o & ~(pop_i ? top_mask : '0)) | push_mask;
  end
endmodule

// File: rtl/irq3_vic.sv
module irq3_vic
  import irq3_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 10,
  parameter int unsigned NUM_TOP  = 2,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] irq_i,
  input  logic [NUM_VEC-1:0] clr_i,
  input  logic [NUM_VEC-1:0] lvl_sel_i,
  input  logic               gie_i,
  input  logic               reti_i,
  output logic               take_o,
  output logic [ADDR_W-1:0]  vec_addr_o
);
  localparam int unsigned IDX_W = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_LVL-1:0] svc_q;
  logic               grant;
  logic [IDX_W-1:0]   grant_idx;
  logic [NUM_VEC-1:0] grant_mask;
  lvl_e               grant_lvl;

  irq3_pend_bank #(.NUM_VEC(NUM_VEC)) i_pend (
    .clk_i, .rst_ni,
    .set_i  (irq_i),
    .clr_i  (clr_i),
    .take_i (grant_mask),
    .pend_o (pend_q)
  );

  irq3_arbiter #(.NUM_VEC(NUM_VEC), .NUM_TOP(NUM_TOP)) i_arb (
    .pend_i       (pend_q),
    .sel_i        (lvl_sel_i),
    .gie_i        (gie_i),
    .svc_i        (svc_q),
    .grant_o      (grant),
    .grant_idx_o  (grant_idx),
    .grant_mask_o (grant_mask),
    .grant_lvl_o  (grant_lvl)
  );

  irq3_svc_stack i_svc (
    .clk_i, .rst_ni,
    .push_i     (grant),
    .push_lvl_i (grant_lvl),
    .pop_i      (reti_i),
    .svc_o      (svc_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o     <= 1'b0;
      vec_addr_o <= '0;
    end else begin
      take_o <= grant;
      if (grant) vec_addr_o <= ADDR_W'(VEC_BASE + VEC_STEP * int'(grant_idx));
    end
  end
endmodule

module irq3_vic_chk #(
  parameter int unsigned NUM_VEC  = 10,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8,
  parameter int unsigned ADDR_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               gie_i,
  input logic               take_o,
  input logic [ADDR_W-1:0]  vec_addr_o,
  input logic [NUM_VEC-1:0] pend_i,
  input logic [2:0]         svc_i
);
  localparam int unsigned ADDR_MAX = VEC_BASE + VEC_STEP * (NUM_VEC - 1);

  assert_gie_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(gie_i));

  assert_addr_grid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (int'(vec_addr_o) >= int'(VEC_BASE) && int'(vec_addr_o) <= int'(ADDR_MAX)
                && (int'(vec_addr_o) - int'(VEC_BASE)) % int'(VEC_STEP) == 0));

  assert_take_needs_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(|pend_i));

  assert_nest_grows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (svc_i > $past(svc_i)));
endmodule

bind irq3_vic irq3_vic_chk #(
  .NUM_VEC(NUM_VEC), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i, .rst_ni, .gie_i, .take_o, .vec_addr_o,
  .pend_i (pend_q),
  .svc_i  (svc_q)
);

// File: tb/test_irq3_vic.sv
`timescale 1ns/1ps
module test_irq3_vic;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] irq = '0, clr = '0, lvl = '0;
  logic          gie = 1'b0, reti = 1'b0;
  logic          take;
  logic [7:0]    addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq3_vic i_irq3_vic (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .clr_i(clr), .lvl_sel_i(lvl),
    .gie_i(gie), .reti_i(reti), .take_o(take), .vec_addr_o(addr)
  );

  // behavioural reference
  bit m_pend [NV];
  bit m_svc [3];
  bit m_take;
  int m_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      foreach (m_svc[i]) m_svc[i] = 0;
      m_take = 0; m_addr = 0;
    end else begin
      int top, best, best_lvl;
      top = -1;
      for (int l = 0; l < 3; l++) if (m_svc[l]) top = l;
      best = -1; best_lvl = -1;
      for (int v = 0; v < NV; v++) begin
        int lv;
        lv = !lvl[v] ? 0 : (v < 2 ? 2 : 1);
        if (m_pend[v] && gie && lv > top && lv > best_lvl) begin
          best = v; best_lvl = lv;
        end
      end
      if (reti && top >= 0) m_svc[top] = 0;
      if (best >= 0) m_svc[best_lvl] = 1;
      m_take = (best >= 0);
      if (best >= 0) m_addr = 3 + 8 * best;
      for (int v = 0; v < NV; v++) begin
        bit p;
        p = m_pend[v] && (v != best);
        if (irq[v]) p = 1;
        if (clr[v]) p = 0;
        m_pend[v] = p;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(take == m_take, "R7 model take", int'(take), int'(m_take));
    chk(int'(addr) == m_addr, "R2 model addr", int'(addr), m_addr);
  end

  task automatic step(); @(negedge clk); endtask

  task automatic pulse_irq(logic [NV-1:0] m);
    irq = m; step(); irq = '0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; step(); reti = 1'b0;
  endtask

  task automatic exp_take(bit t, int a, string req);
    chk(take == t, req, int'(take), int'(t));
    if (t) chk(int'(addr) == a, req, int'(addr), a);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    step(); step();
    exp_take(0, 0, "R1 reset take");
    chk(addr == 8'h00, "R1 reset addr", int'(addr), 0);
    rst_n = 1'b1;
    step();
    gie = 1'b1;

    // R2 / R7: single low request, one-clock strobe
    pulse_irq(NV'(1) << 4);
    exp_take(0, 0, "R7 no take in sampling cycle");
    step(); exp_take(1, 'h23, "R2 vector 4 address");
    step(); exp_take(0, 0, "R7 strobe one clock");
    pulse_reti();

    // R5: same level, lowest index first; R8 release after return
    pulse_irq((NV'(1) << 3) | (NV'(1) << 7));
    step(); exp_take(1, 'h1B, "R5 lowest index wins");
    step(); exp_take(0, 0, "R6 equal level held");
    pulse_reti(); exp_take(0, 0, "R8 return edge no take");
    step(); exp_take(1, 'h3B, "R8 held taken after return");
    pulse_reti();

    // R4 / R3: high beats low
    lvl = NV'(1) << 9;
    pulse_irq((NV'(1) << 0) | (NV'(1) << 9));
    step(); exp_take(1, 'h4B, "R4 high level wins");
    pulse_reti();
    step(); exp_take(1, 'h03, "R4 low taken later");
    pulse_reti();

    // R3: top level on vector 1 beats high on vector 2
    lvl = (NV'(1) << 1) | (NV'(1) << 2);
    pulse_irq((NV'(1) << 1) | (NV'(1) << 2));
    step(); exp_take(1, 'h0B, "R3 top level beats high");
    pulse_reti();
    step(); exp_take(1, 'h13, "R3 high after top");
    pulse_reti();

    // R6 / R8 / R11: three-deep nest and unwind
    lvl = (NV'(1) << 0) | (NV'(1) << 4) | (NV'(1) << 5);
    pulse_irq(NV'(1) << 3);
    step(); exp_take(1, 'h1B, "R6 low entry");
    pulse_irq(NV'(1) << 6);
    step(); exp_take(0, 0, "R6 equal low held");
    step(); exp_take(0, 0, "R6 equal low still held");
    pulse_irq(NV'(1) << 5);
    step(); exp_take(1, 'h2B, "R6 high preempts low");
    pulse_irq(NV'(1) << 4);
    step(); exp_take(0, 0, "R6 equal high held");
    pulse_irq(NV'(1) << 0);
    step(); exp_take(1, 'h03, "R6 top preempts high");
    pulse_reti(); exp_take(0, 0, "R8 pop top");
    step(); exp_take(0, 0, "R8 high still in service");
    pulse_reti(); exp_take(0, 0, "R8 pop high");
    step(); exp_take(1, 'h23, "R8 held high taken");
    pulse_reti(); exp_take(0, 0, "R8 pop high again");
    step(); exp_take(0, 0, "R8 low in service holds low");
    pulse_reti(); exp_take(0, 0, "R8 pop low");
    step(); exp_take(1, 'h33, "R8 held low taken");
    pulse_reti();
    pulse_reti(); exp_take(0, 0, "R11 return on empty");
    pulse_irq(NV'(1) << 3);
    step(); exp_take(1, 'h1B, "R11 empty stack intact");
    pulse_reti();

    // R9: global enable
    gie = 1'b0;
    pulse_irq(NV'(1) << 2);
    step(); exp_take(0, 0, "R9 disabled no take");
    step(); exp_take(0, 0, "R9 disabled still none");
    gie = 1'b1;
    step(); exp_take(1, 'h13, "R9 pending survives disable");
    pulse_reti();

    // R10: clear, and clear beats set
    gie = 1'b0;
    pulse_irq(NV'(1) << 8);
    clr = NV'(1) << 8; step(); clr = '0;
    irq = NV'(1) << 7; clr = NV'(1) << 7; step(); irq = '0; clr = '0;
    gie = 1'b1;
    step(); exp_take(0, 0, "R10 cleared not taken");
    step(); exp_take(0, 0, "R10 clear wins over set");

    // random phase, model compared every clock
    for (int n = 0; n < 3000; n++) begin
      irq  = NV'($urandom) & NV'($urandom) & NV'($urandom);
      clr  = (($urandom % 8) == 0) ? (NV'($urandom) & NV'($urandom)) : '0;
      if (($urandom % 16) == 0) lvl = NV'($urandom);
      gie  = ($urandom % 10) != 0;
      reti = ($urandom % 4) == 0;
      step();
    end
    irq = '0; clr = '0; reti = 1'b0;
    step(); step();
    finish_run();
  end
endmodule